// File: doc/BRIEF.md
# Console Bus Address Decoder

This block sits between an 8-bit processor bus with a 16-bit address and the three things that bus can reach: a 2 KiB work RAM held inside the block, a register window belonging to an external video controller, and an external cartridge program ROM behind a fixed, bank-free mapping. Each cycle it looks at the address and the two strobes. It raises at most one region select. It writes the RAM, or passes a video register write on. It translates a program address into a ROM byte offset. One clock later it returns the read data.

The small RAM and the program ROM are both mirrored. The RAM index keeps only the low eleven address bits, so the 8 KiB RAM range holds four copies of the array. A cartridge with a single 16 KiB bank appears twice across the upper 32 KiB. A static bank-count input picks the ROM mask. Writes aimed at the ROM range are dropped. A separate pattern-memory address passes straight through.

Access flow is plain strobes with no back-pressure. The block accepts a read or a write on every cycle a strobe is high. Read data is always ready exactly one cycle later, and nothing can stall the processor.

Top module: `console_bus_decoder`

## Requirements
- R1: An access with `cpu_addr` below 0x2000 targets the RAM at index `cpu_addr & 0x07FF`. For example, a byte written at 0x0123 reads back at 0x0923 and 0x1923, and 0x17FF aliases 0x07FF.
- R2: `cpu_rdata` changes only at a clock edge. After an edge where `cpu_rd` was high, it shows the addressed region's data. After an edge where `cpu_rd` was low, it is 0x00.
- R3: Addresses 0x2000 to 0x3FFF assert `vid_sel` while a strobe is high, and assert `vid_wr` on a write. A read there returns 0x00.
- R4: Addresses 0x4000 to 0x7FFF assert no select, and a read there returns 0x00.
- R5: A read at 0x8000 or above asserts `rom_sel`. The byte on `rom_rdata` during that cycle is returned on `cpu_rdata` after the next edge.
- R6: `rom_offset` is `cpu_addr & 0x7FFF` when `cart_two_banks` is 1, and `cpu_addr & 0x3FFF` when it is 0, so a single 16 KiB bank is mirrored.
- R7: A write at 0x8000 or above asserts no select and leaves the RAM unchanged.
- R8: `chr_addr_out` equals `chr_addr_in` in the same cycle.
- R9: At most one of `ram_sel`, `vid_sel`, `rom_sel` is high. None is high when both strobes are low.
- R10: After reset, `cpu_rdata` is 0x00 until the first read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cart_two_banks | input | 1 | 1 = 32 KiB program ROM, 0 = one 16 KiB bank (static) |
| cpu_rdata | output | 8 | Read data, one cycle after the read |
| ram_sel | output | 1 | Work RAM selected |
| vid_sel | output | 1 | Video register window selected |
| vid_wr | output | 1 | Write into the video window |
| rom_sel | output | 1 | Program ROM read |
| rom_offset | output | 15 | Byte offset into program ROM |
| rom_rdata | input | 8 | Program ROM byte for `rom_offset`, same cycle |
| chr_addr_in | input | 14 | Pattern-memory address from the video side |
| chr_addr_out | output | 14 | Pattern-memory address to the cartridge |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high in the same cycle. They also assume that `cart_two_banks` holds steady while accesses run. The stimulus drives one strobe per cycle at most. It changes the bank-count input only during an idle cycle between groups of accesses. The external ROM is modelled as a combinational function of `rom_offset`, so every expected ROM byte comes from the address mask alone.

// File: rtl/bus_dec_pkg.sv
package bus_dec_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;

  // region boundaries on the processor bus
  parameter logic [15:0] VID_BASE  = 16'h2000;
  parameter logic [15:0] OPEN_BASE = 16'h4000;
  parameter logic [15:0] ROM_BASE  = 16'h8000;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_RAM  = 3'd1,
    RGN_VID  = 3'd2,
    RGN_OPEN = 3'd3,
    RGN_ROM  = 3'd4
  } region_e;
endpackage

// File: rtl/bus_region_decode.sv
module bus_region_decode
  import bus_dec_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output region_e       region,
  output logic          ram_sel,
  output logic          vid_sel,
  output logic          vid_wr,
  output logic          rom_sel
);
  logic active;

  always_comb begin
    active = rd | wr;
    if (!active)                      region = RGN_NONE;
    else if (addr < AW'(VID_BASE))    region = RGN_RAM;
    else if (addr < AW'(OPEN_BASE))   region = RGN_VID;
    else if (addr < AW'(ROM_BASE))    region = RGN_OPEN;
    else                              region = RGN_ROM;
  end

  always_comb begin
    ram_sel = (region == RGN_RAM);
    vid_sel = (region == RGN_VID);
    vid_wr  = vid_sel & wr;
    // the program ROM is read-only: writes there are dropped
    rom_sel = (region == RGN_ROM) & rd;
  end
endmodule

// File: rtl/bus_work_ram.sv
module bus_work_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) rdata <= mem[idx];
  end
endmodule

// File: rtl/bus_rom_map.sv
module bus_rom_map #(
  parameter int AW    = 16,
  parameter int OFF_W = 15
) (
  input  logic [AW-1:0]    addr,
  input  logic             two_banks,
  output logic [OFF_W-1:0] offset
);
  localparam int BANK_W = OFF_W - 1;

  logic [OFF_W-1:0] mask;

  always_comb begin
    mask   = two_banks ? {OFF_W{1'b1}} : {1'b0, {BANK_W{1'b1}}};
    offset = addr[OFF_W-1:0] & mask;
  end
endmodule

// File: rtl/console_bus_decoder.sv
module console_bus_decoder
  import bus_dec_pkg::*;
#(
  parameter int RAM_AW = 11,
  parameter int OFF_W  = 15,
  parameter int CHR_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              cart_two_banks,
  output logic [7:0]        cpu_rdata,
  output logic              ram_sel,
  output logic              vid_sel,
  output logic              vid_wr,
  output logic              rom_sel,
  output logic [OFF_W-1:0]  rom_offset,
  input  logic [7:0]        rom_rdata,
  input  logic [CHR_W-1:0]  chr_addr_in,
  output logic [CHR_W-1:0]  chr_addr_out
);
  region_e     region;
  region_e     rd_region_q;
  logic [7:0]  ram_q;
  logic [7:0]  rom_q;

  bus_region_decode #(.AW(16)) u_dec (
    .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr), .region(region),
    .ram_sel(ram_sel), .vid_sel(vid_sel), .vid_wr(vid_wr), .rom_sel(rom_sel)
  );

  bus_work_ram #(.AW(RAM_AW), .DW(8)) u_ram (
    .clk(clk), .we(ram_sel & cpu_wr), .re(ram_sel & cpu_rd),
    .idx(cpu_addr[RAM_AW-1:0]), .wdata(cpu_wdata), .rdata(ram_q)
  );

  bus_rom_map #(.AW(16), .OFF_W(OFF_W)) u_map (
    .addr(cpu_addr), .two_banks(cart_two_banks), .offset(rom_offset)
  );

  assign chr_addr_out = chr_addr_in;

  // remember which region the pending read targets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_region_q <= RGN_NONE;
      rom_q       <= '0;
    end else begin
      rd_region_q <= cpu_rd ? region : RGN_NONE;
      if (rom_sel) rom_q <= rom_rdata;
    end
  end

  always_comb begin
    case (rd_region_q)
      RGN_RAM: cpu_rdata = ram_q;
      RGN_ROM: cpu_rdata = rom_q;
      default: cpu_rdata = 8'h00;
    endcase
  end

  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, vid_sel, rom_sel}));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd | cpu_wr) |-> !(ram_sel | vid_sel | rom_sel | vid_wr));
  a_r2_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> cpu_rdata == 8'h00);
  a_r3_vid_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr >= 16'h2000 && cpu_addr < 16'h4000) |=> cpu_rdata == 8'h00);
  a_r4_open_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr >= 16'h4000 && cpu_addr < 16'h8000) |=> cpu_rdata == 8'h00);
  a_r5_rom_return: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15]) |=> cpu_rdata == $past(rom_rdata));
  a_r6_single_bank_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    !cart_two_banks |-> !rom_offset[OFF_W-1]);
  a_r7_rom_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |-> !(ram_sel | vid_sel | rom_sel));
  a_r8_chr_pass: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr_out == chr_addr_in);
endmodule

// File: tb/console_bus_decoder_tb.sv
module console_bus_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic        cart_two_banks = 1'b1;
  logic [7:0]  cpu_rdata;
  logic        ram_sel, vid_sel, vid_wr, rom_sel;
  logic [14:0] rom_offset;
  logic [7:0]  rom_rdata;
  logic [13:0] chr_addr_in = '0;
  logic [13:0] chr_addr_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // external ROM model: a fixed function of the offset
  assign rom_rdata = rom_offset[7:0] ^ {1'b0, rom_offset[14:8]};

  console_bus_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cart_two_banks(cart_two_banks),
    .cpu_rdata(cpu_rdata), .ram_sel(ram_sel), .vid_sel(vid_sel), .vid_wr(vid_wr),
    .rom_sel(rom_sel), .rom_offset(rom_offset), .rom_rdata(rom_rdata),
    .chr_addr_in(chr_addr_in), .chr_addr_out(chr_addr_out)
  );

  function automatic logic [7:0] rom_byte(input logic [15:0] a, input logic two);
    logic [14:0] o;
    o = two ? a[14:0] : {1'b0, a[13:0]};
    return o[7:0] ^ {1'b0, o[14:8]};
  endfunction

  function automatic string req_of(input logic [15:0] a, input logic [1:0] op);
    if (op == 2'd0)     return "R9";
    if (a < 16'h2000)   return "R1";
    if (a < 16'h4000)   return "R3";
    if (a < 16'h8000)   return "R4";
    if (op == 2'd1)     return "R7";
    return "R5";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // {op(0 idle,1 wr,2 rd), addr, wdata, exp rdata, exp {ram,vid,rom,vid_wr}, rom-model}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {2'd1, 16'h0123, 8'h5A, 8'h00, 4'b1000, 1'b0}, // R1 write
    {2'd2, 16'h0923, 8'h00, 8'h5A, 4'b1000, 1'b0}, // R1 mirror 2
    {2'd2, 16'h1923, 8'h00, 8'h5A, 4'b1000, 1'b0}, // R1 mirror 4
    {2'd1, 16'h17FF, 8'hC3, 8'h00, 4'b1000, 1'b0}, // R1 top index
    {2'd2, 16'h07FF, 8'h00, 8'hC3, 4'b1000, 1'b0}, // R1 alias
    {2'd1, 16'h2003, 8'h11, 8'h00, 4'b0101, 1'b0}, // R3 write
    {2'd2, 16'h3FFF, 8'h00, 8'h00, 4'b0100, 1'b0}, // R3 read zero
    {2'd2, 16'h4020, 8'h00, 8'h00, 4'b0000, 1'b0}, // R4
    {2'd2, 16'h7FFF, 8'h00, 8'h00, 4'b0000, 1'b0}, // R4 edge
    {2'd2, 16'hC123, 8'h00, 8'h00, 4'b0010, 1'b1}, // R5/R6
    {2'd2, 16'h8000, 8'h00, 8'h00, 4'b0010, 1'b1}, // R5 base
    {2'd1, 16'h8123, 8'hFF, 8'h00, 4'b0000, 1'b0}, // R7 dropped write
    {2'd2, 16'h0123, 8'h00, 8'h5A, 4'b1000, 1'b0}, // R7 RAM unchanged
    {2'd0, 16'h0123, 8'h00, 8'h00, 4'b0000, 1'b0}, // R9/R2 idle
    {2'd2, 16'hFFFF, 8'h00, 8'h00, 4'b0010, 1'b1}  // R5 top
  };

  task automatic access(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d;
    cpu_rd = (op == 2'd2); cpu_wr = (op == 2'd1);
  endtask

  initial begin
    #1;
    check("R10", "rdata in reset", int'(cpu_rdata), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", "rdata after reset", int'(cpu_rdata), 0);

    foreach (VEC[i]) begin
      logic [1:0] op; logic [15:0] a; logic [7:0] d, e; logic [3:0] s; logic rm;
      {op, a, d, e, s, rm} = VEC[i];
      access(op, a, d);
      #1;
      check(req_of(a, op), "selects", int'({ram_sel, vid_sel, rom_sel, vid_wr}), int'(s));
      if (rm) check("R6", "rom offset", int'(rom_offset), int'({1'b0, a[14:0]}));
      @(posedge clk); #1;
      check(op == 2'd0 ? "R2" : req_of(a, op), "rdata",
            int'(cpu_rdata), int'(rm ? rom_byte(a, 1'b1) : e));
    end

    // one 16 KiB bank: mirrored
    access(2'd0, 16'h0000, 8'h00);
    cart_two_banks = 1'b0;
    access(2'd2, 16'hC123, 8'h00);
    #1 check("R6", "single-bank offset", int'(rom_offset), 15'h0123);
    @(posedge clk); #1;
    check("R6", "single-bank data", int'(cpu_rdata), int'(rom_byte(16'hC123, 1'b0)));
    check("R6", "single-bank mirror data", int'(rom_byte(16'hC123, 1'b0)),
          int'(rom_byte(16'h8123, 1'b0)));
    access(2'd2, 16'hBFFF, 8'h00);
    #1 check("R6", "single-bank top", int'(rom_offset), 15'h3FFF);

    // read then idle: data returns to zero
    access(2'd0, 16'h0123, 8'h00);
    @(posedge clk); #1;
    check("R2", "idle rdata", int'(cpu_rdata), 0);

    // pattern address passthrough
    chr_addr_in = 14'h2A5C; #1;
    check("R8", "chr pass", int'(chr_addr_out), 14'h2A5C);
    chr_addr_in = 14'h3FFF; #1;
    check("R8", "chr pass max", int'(chr_addr_out), 14'h3FFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule